// File: doc/BRIEF.md
# Section AIS Persistence Detector

This block watches one trace byte per frame together with an alarm-indication signal that a line-level monitor supplies. It flags a section alarm-indication condition when, frame after frame, the trace byte is all ones and the line alarm is present. A frame strobe marks each byte. A persistence-select input chooses the number of consecutive frames the condition must hold before the detector changes state: 3 or 5. The same count governs both entry into the alarm and exit from it.

The detector has three outputs. The live bit follows the filtered condition. The sticky status bit latches every change of the live bit and stays set until a CPU write-one-to-clear strobe. The interrupt output is asserted while status is set and the mask input is low. The line alarm is detected elsewhere; this block only consumes it.

Top module: `sais_detector`

## Requirements
- R1: A frame is a match when, in the cycle `frame_stb` is high, `trace_byte` equals 8'hFF and `line_ais` is 1. Cycles with `frame_stb` low are ignored and never advance or reset the count.
- R2: While `live` is 0, it becomes 1 after N consecutive match frames. N is 3 when `persist_sel` is 0 and 5 when it is 1. `live` updates at the clock edge that samples the N-th frame.
- R3: While `live` is 1, it returns to 0 after N consecutive non-match frames. A non-match is either `line_ais` low or `trace_byte` not equal to 8'hFF.
- R4: `status` is set at the same edge at which `live` rises or falls.
- R5: `irq` is 1 exactly when `status` is 1 and `irq_mask` is 0. It follows both with one register of delay.
- R6: A frame that agrees with the current `live` value resets the persistence count to zero.
- R7: A high `stat_clr` clears `status` at the next edge. If a `live` change happens at that same edge, the set wins.
- R8: In a cycle where `persist_sel` differs from its registered value, the count is reset and any frame in that cycle is discarded.
- R9: After synchronous reset, `live`, `status` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse per frame |
| trace_byte | input | 8 | Trace byte of the current frame |
| line_ais | input | 1 | Line alarm indication from the line monitor |
| persist_sel | input | 1 | 0: 3 frames, 1: 5 frames |
| irq_mask | input | 1 | 1 masks the interrupt |
| stat_clr | input | 1 | Write-one-to-clear strobe for status |
| live | output | 1 | Filtered alarm state |
| status | output | 1 | Sticky change indication |
| irq | output | 1 | Interrupt request |

## Verification
The main sweep covers every 8-frame match/non-match sequence under both persistence settings. Non-matches alternate between a wrong byte and an absent line alarm, so the sweep shows that either cause alone breaks a streak and that streaks one frame short never switch `live`. Directed patterns cover four further cases:
- idle cycles carrying a matching byte, which must not count;
- a persistence-select change in the middle of a streak, which separates a reset count from a carried-over count;
- a clear strobe that coincides with a `live` toggle;
- mask toggling while status is held.

// File: rtl/sais_pkg.sv
package sais_pkg;
  typedef enum logic {
    PERSIST_SHORT = 1'b0,
    PERSIST_LONG  = 1'b1
  } persist_e;

  function automatic int unsigned cnt_width(input int unsigned max_n);
    int unsigned w;
    w = 1;
    while ((1 << w) <= max_n) w++;
    return w;
  endfunction
endpackage

// File: rtl/sais_match.sv
module sais_match #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] trace_byte,
  input  logic              line_ais,
  output logic              match
);
  localparam logic [BYTE_W-1:0] ALL_ONES = {BYTE_W{1'b1}};

  always_comb match = line_ais && (trace_byte == ALL_ONES);
endmodule

// File: rtl/sais_persist.sv
module sais_persist
  import sais_pkg::*;
#(
  parameter int unsigned SHORT_N = 3,
  parameter int unsigned LONG_N  = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_stb,
  input  logic match,
  input  logic persist_sel,
  output logic live,
  output logic toggle
);
  localparam int unsigned MAX_N = (SHORT_N > LONG_N) ? SHORT_N : LONG_N;
  localparam int unsigned CW    = cnt_width(MAX_N);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_N - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_N - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          sel_q;
  logic          sel_chg;
  logic          take;

  always_comb begin
    last    = (persist_e'(persist_sel) == PERSIST_LONG) ? LONG_LAST : SHORT_LAST;
    sel_chg = persist_sel != sel_q;
    take    = frame_stb && !sel_chg;
    toggle  = take && (match != live) && (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      live  <= 1'b0;
      sel_q <= persist_sel;
    end else begin
      sel_q <= persist_sel;
      if (sel_chg) begin
        cnt <= '0;
      end else if (take) begin
        if (match == live) begin
          cnt <= '0;
        end else if (toggle) begin
          cnt  <= '0;
          live <= ~live;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R6: the count never reaches the selected persistence value
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= last || sel_chg);

  // R6: an agreeing frame leaves the count at zero
  a_r6_agree_resets: assert property (@(posedge clk) disable iff (rst)
    (take && match == live) |=> cnt == '0);

  // R1: live changes only at an edge that sampled a frame strobe
  a_r1_strobe_only: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(live));

  // R8: a select change discards the frame and clears the count
  a_r8_sel_reset: assert property (@(posedge clk) disable iff (rst)
    sel_chg |=> (cnt == '0) && $stable(live));
endmodule

// File: rtl/sais_status.sv
module sais_status (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic stat_clr,
  input  logic irq_mask,
  output logic status,
  output logic irq
);
  logic status_nxt;

  always_comb begin
    if (set_evt)       status_nxt = 1'b1;
    else if (stat_clr) status_nxt = 1'b0;
    else               status_nxt = status;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= 1'b0;
      irq    <= 1'b0;
    end else begin
      status <= status_nxt;
      irq    <= status_nxt && !irq_mask;
    end
  end

  // R5: interrupt only with status present
  a_r5_irq_needs_status: assert property (@(posedge clk) disable iff (rst)
    irq |-> status);

  // R5: a mask held high keeps the interrupt low
  a_r5_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    irq_mask |=> !irq);

  // R7: clear without a set event empties status
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !set_evt) |=> !status);

  // R7: a set event wins over a coincident clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> status);
endmodule

// File: rtl/sais_detector.sv
module sais_detector #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned SHORT_N = 3,
  parameter int unsigned LONG_N  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb,
  input  logic [BYTE_W-1:0] trace_byte,
  input  logic              line_ais,
  input  logic              persist_sel,
  input  logic              irq_mask,
  input  logic              stat_clr,
  output logic              live,
  output logic              status,
  output logic              irq
);
  logic match;
  logic toggle;

  sais_match #(.BYTE_W(BYTE_W)) u_match (
    .trace_byte (trace_byte),
    .line_ais   (line_ais),
    .match      (match)
  );

  sais_persist #(.SHORT_N(SHORT_N), .LONG_N(LONG_N)) u_persist (
    .clk         (clk),
    .rst         (rst),
    .frame_stb   (frame_stb),
    .match       (match),
    .persist_sel (persist_sel),
    .live        (live),
    .toggle      (toggle)
  );

  sais_status u_status (
    .clk      (clk),
    .rst      (rst),
    .set_evt  (toggle),
    .stat_clr (stat_clr),
    .irq_mask (irq_mask),
    .status   (status),
    .irq      (irq)
  );

  // R4: any live transition leaves status set
  a_r4_status_on_change: assert property (@(posedge clk) disable iff (rst)
    (live != $past(live)) |-> status);

  // R9: outputs clear while in reset
  a_r9_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (!live && !status && !irq));
endmodule

// File: tb/sais_detector_tb.sv
module sais_detector_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_stb = 1'b0;
  logic [7:0] trace_byte = 8'h00;
  logic       line_ais = 1'b0;
  logic       persist_sel = 1'b0;
  logic       irq_mask = 1'b0;
  logic       stat_clr = 1'b0;
  logic       live, status, irq;

  int checks = 0;
  int fails  = 0;

  // Reference state, built from the requirements
  logic m_live, m_stat;
  int   m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  sais_detector u_dut (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .trace_byte(trace_byte),
    .line_ais(line_ais), .persist_sel(persist_sel), .irq_mask(irq_mask),
    .stat_clr(stat_clr), .live(live), .status(status), .irq(irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " live"}, live, m_live);
    check({req, " status"}, status, m_stat);
    check({req, " irq"}, irq, m_stat && !irq_mask);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; frame_stb = 1'b0; stat_clr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_live = 1'b0; m_stat = 1'b0; m_cnt = 0;
  endtask

  // One frame: driven at a falling edge, sampled at the next falling edge
  task automatic frame(input logic [7:0] b, input logic a, input logic clr);
    int n;
    logic c;
    n = persist_sel ? 5 : 3;
    c = (b == 8'hFF) && a;
    @(negedge clk);
    frame_stb = 1'b1; trace_byte = b; line_ais = a; stat_clr = clr;
    @(negedge clk);
    frame_stb = 1'b0; stat_clr = 1'b0;
    if (clr) m_stat = 1'b0;
    if (c == m_live) m_cnt = 0;
    else begin
      m_cnt++;
      if (m_cnt == n) begin
        m_live = c; m_cnt = 0; m_stat = 1'b1;
      end
    end
  endtask

  initial begin
    do_reset();
    check("R9 reset", live, 1'b0);
    check("R9 reset", status, 1'b0);
    check("R9 reset", irq, 1'b0);

    // R1/R2/R3/R6 sweep: all 8-frame sequences, both persistence settings
    for (int sel = 0; sel < 2; sel++) begin
      for (int pat = 0; pat < 256; pat++) begin
        persist_sel = sel[0];
        irq_mask = pat[7] ^ pat[0];
        do_reset();
        for (int i = 0; i < 8; i++) begin
          if (pat[i]) frame(8'hFF, 1'b1, 1'b0);
          else if (i % 2 == 0) frame(8'hFE, 1'b1, 1'b0);
          else frame(8'hFF, 1'b0, 1'b0);
          check_all("R2/R3/R6 sweep");
        end
        // R7 clear without a toggle
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); stat_clr = 1'b0; m_stat = 1'b0;
        check("R7 clear", status, 1'b0);
        check("R5 irq after clear", irq, 1'b0);
      end
    end

    // R1: non-strobe cycles with a matching byte do not count
    persist_sel = 1'b0; irq_mask = 1'b0;
    do_reset();
    @(negedge clk); trace_byte = 8'hFF; line_ais = 1'b1;
    repeat (10) @(negedge clk);
    check("R1 idle ignored", live, 1'b0);
    check("R1 idle ignored", status, 1'b0);

    // R7: a clear coincident with the toggling frame loses
    frame(8'hFF, 1'b1, 1'b0);
    frame(8'hFF, 1'b1, 1'b0);
    frame(8'hFF, 1'b1, 1'b1);
    check("R7 set wins", live, 1'b1);
    check("R7 set wins", status, 1'b1);
    check("R4 status on rise", irq, 1'b1);

    // R5: mask toggling while status held
    @(negedge clk); irq_mask = 1'b1;
    @(negedge clk);
    check("R5 masked", irq, 1'b0);
    irq_mask = 1'b0;
    @(negedge clk);
    check("R5 unmasked", irq, 1'b1);

    // R8: select change mid-streak resets the count
    do_reset();
    frame(8'hFF, 1'b1, 1'b0);
    frame(8'hFF, 1'b1, 1'b0);
    @(negedge clk); persist_sel = 1'b1;
    @(negedge clk);
    frame(8'hFF, 1'b1, 1'b0);
    frame(8'hFF, 1'b1, 1'b0);
    frame(8'hFF, 1'b1, 1'b0);
    frame(8'hFF, 1'b1, 1'b0);
    check("R8 count restarted", live, 1'b0);
    frame(8'hFF, 1'b1, 1'b0);
    check("R8 five after change", live, 1'b1);

    // R8: a frame arriving in the change cycle is discarded
    persist_sel = 1'b0;
    do_reset();
    frame(8'hFF, 1'b1, 1'b0);
    frame(8'hFF, 1'b1, 1'b0);
    @(negedge clk);
    persist_sel = 1'b1; frame_stb = 1'b1; trace_byte = 8'hFF; line_ais = 1'b1;
    @(negedge clk); frame_stb = 1'b0;
    frame(8'hFF, 1'b1, 1'b0);
    frame(8'hFF, 1'b1, 1'b0);
    frame(8'hFF, 1'b1, 1'b0);
    frame(8'hFF, 1'b1, 1'b0);
    check("R8 change frame discarded", live, 1'b0);
    frame(8'hFF, 1'b1, 1'b0);
    check("R8 change frame discarded", live, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule